// File: doc/BRIEF.md
# SD Host Command Path

This block is the command side of an SD host controller. Software first loads a 32-bit command argument and then writes a 16-bit command word; the write of the command word launches the command. The block builds a 48-bit command frame with a computed CRC7, shifts it out on the CMD line one bit per SD clock, and then listens on the same line for the card's response of the length the command word selects.

Responses are captured into four 32-bit response registers. A long (136-bit) response is stored without its CRC byte, so its 120 payload bits sit right-aligned and appear shifted down by eight bits. Short responses can be checked for CRC and for a matching command index. Results are reported through sticky status bits that software clears by writing ones, and two inhibit flags tell software when a new command may be written. For busy-type responses the block keeps the DAT-side inhibit raised while the card holds DAT0 low.

The SD clock is derived internally from the system clock; the block changes CMD while the SD clock is low and samples CMD on its rising edge.

Top module: `sdc_cmd_path`

## Requirements
- R1: After reset the status bits, the inhibit flags and all response registers are zero, `cmd_oe` is low and `cmd_out` is high.
- R2: An accepted command is sent MSB first as 48 bits: 0, 1, the 6-bit index, the 32-bit argument, the 7-bit CRC and a final 1; `cmd_out` changes only while `sd_clk` is low.
- R3: The frame CRC is the CRC7 with polynomial x^7 + x^3 + 1 (register cleared to zero) over the first 40 frame bits.
- R4: The command word is decoded as: index in bits [13:8], data-present in bit 5, index-check enable in bit 4, CRC-check enable in bit 3, response kind in bits [1:0] with 00 none, 01 long 136-bit, 10 short 48-bit, 11 short 48-bit with busy.
- R5: With response kind 00 the command-complete status bit is set once the end bit has been sent, without waiting on the CMD line.
- R6: For a short response, `resp0` receives response bits [39:8] and command-complete is set.
- R7: For a long response, {`resp3`,`resp2`,`resp1`,`resp0`} receives eight zero bits followed by response bits [127:8]; CRC7 is computed over bits [127:8].
- R8: If no start bit is seen within 64 rising SD clock edges after the end bit, timeout and error-summary are set and command-complete is not; a start bit on the 61st edge is accepted.
- R9: With CRC check enabled, a CRC mismatch sets the CRC-error bit; with index check enabled, a short response whose bits [45:40] differ from the command index sets the index-error bit; either sets error-summary alongside command-complete. With the checks disabled the same responses give command-complete alone.
- R10: `pstate[0]` (command inhibit) is high from an accepted command word until completion or timeout; a command word written while it is high is ignored.
- R11: After a busy-type response `pstate[1]` (DAT inhibit) stays high until DAT0 is sampled high; while it is high, a busy-type command without data-present is ignored, but other commands are accepted.
- R12: Status layout is [0] complete, [1] timeout, [2] CRC error, [3] index error, [4] error summary; each bit clears when written with 1 through `sts_clr_mask`, and 0 bits leave it unchanged.
- R13: `pstate` bits [23:20] follow the DAT[3:0] levels; all other bits except [1:0] read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arg_we | input | 1 | Argument register write strobe |
| arg_wdata | input | 32 | Argument write data |
| cmd_we | input | 1 | Command word write strobe; starts a command |
| cmd_wdata | input | 16 | Command word |
| sts_clr_we | input | 1 | Status clear strobe |
| sts_clr_mask | input | 5 | Status bits to clear (1 clears) |
| sts | output | 5 | Sticky status bits |
| pstate | output | 32 | Present state: inhibits and DAT levels |
| resp0 | output | 32 | Response register 0 |
| resp1 | output | 32 | Response register 1 |
| resp2 | output | 32 | Response register 2 |
| resp3 | output | 32 | Response register 3 |
| sd_clk | output | 1 | SD clock to the card |
| cmd_out | output | 1 | CMD line drive value |
| cmd_oe | output | 1 | CMD line drive enable |
| cmd_in | input | 1 | CMD line level from the card |
| dat_in | input | 4 | DAT[3:0] line levels |

## Verification
A card model answers commands with short, long and missing responses, and a scoreboard compares every frame seen on the CMD line against frames predicted from the written index and argument, which separates correct CRC generation and bit order from a design that merely toggles the line. Responses with a corrupted CRC or a foreign index are sent once with checking on and once with it off, telling the error flags apart from the completion flag. Response gaps just inside and beyond the timeout window pin the window length, and holding DAT0 low after a busy-type response separates which commands the DAT inhibit blocks from which it lets through.

// File: rtl/sdc_cmd_pkg.sv
package sdc_cmd_pkg;

  localparam int CMD_W   = 48;
  localparam int STS_W   = 5;
  localparam int STS_DONE = 0;
  localparam int STS_TO   = 1;
  localparam int STS_CRC  = 2;
  localparam int STS_IDX  = 3;
  localparam int STS_ERR  = 4;

  typedef enum logic [1:0] {
    RSP_NONE       = 2'b00,
    RSP_LONG       = 2'b01,
    RSP_SHORT      = 2'b10,
    RSP_SHORT_BUSY = 2'b11
  } rsp_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SEND,
    ST_RESP
  } seq_e;

  typedef struct packed {
    logic [5:0] idx;
    logic       dpres;
    logic       idx_chk;
    logic       crc_chk;
    rsp_kind_e  kind;
  } cmd_word_t;

  function automatic cmd_word_t decode_cmd(input logic [15:0] w);
    cmd_word_t c;
    c.idx     = w[13:8];
    c.dpres   = w[5];
    c.idx_chk = w[4];
    c.crc_chk = w[3];
    c.kind    = rsp_kind_e'(w[1:0]);
    return c;
  endfunction

  function automatic logic [6:0] crc7_step(input logic [6:0] c, input logic d);
    logic fb;
    fb = d ^ c[6];
    return {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
  endfunction

  function automatic logic [6:0] crc7_of40(input logic [39:0] v);
    logic [6:0] c;
    c = '0;
    for (int i = 39; i >= 0; i--) c = crc7_step(c, v[i]);
    return c;
  endfunction

endpackage

// File: rtl/sdc_clk_div.sv
module sdc_clk_div #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic sd_clk,
  output logic fall_stb,
  output logic rise_stb
);
  localparam int CW   = $clog2(DIV);
  localparam int HALF = DIV / 2;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);
  localparam logic [CW-1:0] MID  = CW'(HALF - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          clk_q, clk_d;

  always_comb begin
    cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    clk_d = clk_q;
    if (cnt_q == LAST)     clk_d = 1'b0;
    else if (cnt_q == MID) clk_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      clk_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      clk_q <= clk_d;
    end
  end

  assign sd_clk   = clk_q;
  assign fall_stb = (cnt_q == LAST);
  assign rise_stb = (cnt_q == MID);

  a_r2_edges_apart: assert property (@(posedge clk) disable iff (!rst_n)
    rise_stb |=> sd_clk);

endmodule

// File: rtl/sdc_crc7_acc.sv
module sdc_crc7_acc import sdc_cmd_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       en,
  input  logic       d,
  output logic [6:0] crc
);
  logic [6:0] crc_q, crc_d;

  always_comb begin
    crc_d = crc_q;
    if (clr)     crc_d = '0;
    else if (en) crc_d = crc7_step(crc_q, d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= '0;
    else        crc_q <= crc_d;
  end

  assign crc = crc_q;

endmodule

// File: rtl/sdc_cmd_tx.sv
module sdc_cmd_tx import sdc_cmd_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CMD_W-1:0] frame,
  input  logic             fall_stb,
  output logic             cmd_out,
  output logic             cmd_oe,
  output logic             tx_done
);
  localparam int CNT_W = $clog2(CMD_W + 1);
  localparam logic [CNT_W-1:0] ALL_SENT = CNT_W'(CMD_W);

  logic [CMD_W-1:0] sr_q, sr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic act_q, act_d, out_q, out_d, oe_q, oe_d, done_q, done_d;

  always_comb begin
    sr_d   = sr_q;
    cnt_d  = cnt_q;
    act_d  = act_q;
    out_d  = out_q;
    oe_d   = oe_q;
    done_d = 1'b0;
    if (load) begin
      sr_d  = frame;
      cnt_d = '0;
      act_d = 1'b1;
    end else if (act_q && fall_stb) begin
      if (cnt_q == ALL_SENT) begin
        act_d  = 1'b0;
        oe_d   = 1'b0;
        out_d  = 1'b1;
        done_d = 1'b1;
      end else begin
        oe_d  = 1'b1;
        out_d = sr_q[CMD_W-1];
        sr_d  = {sr_q[CMD_W-2:0], 1'b0};
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      cnt_q  <= '0;
      act_q  <= 1'b0;
      out_q  <= 1'b1;
      oe_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      sr_q   <= sr_d;
      cnt_q  <= cnt_d;
      act_q  <= act_d;
      out_q  <= out_d;
      oe_q   <= oe_d;
      done_q <= done_d;
    end
  end

  assign cmd_out = out_q;
  assign cmd_oe  = oe_q;
  assign tx_done = done_q;

  a_r2_drive_only_active: assert property (@(posedge clk) disable iff (!rst_n)
    oe_q |-> act_q);

  a_r2_release_high: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oe_q) |-> out_q);

endmodule

// File: rtl/sdc_rsp_rx.sv
module sdc_rsp_rx import sdc_cmd_pkg::*; #(
  parameter int LONG_W  = 136,
  parameter int TO_CLKS = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic              long_sel,
  input  logic              rise_stb,
  input  logic              cmd_in,
  output logic              rsp_valid,
  output logic              rsp_timeout,
  output logic [LONG_W-1:0] frame,
  output logic [6:0]        crc_calc
);
  localparam int CNT_W = $clog2(LONG_W + 1);
  localparam int TO_W  = $clog2(TO_CLKS + 1);
  localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_W - 1);
  localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(CMD_W - 1);
  localparam logic [CNT_W-1:0] LONG_TOP   = CNT_W'(LONG_W - 9);
  localparam logic [CNT_W-1:0] CRC_LOW    = CNT_W'(8);
  localparam logic [TO_W-1:0]  TO_LAST    = TO_W'(TO_CLKS - 1);

  typedef enum logic [1:0] {RX_OFF, RX_HUNT, RX_SHIFT} rx_e;

  rx_e               st_q, st_d;
  logic [CNT_W-1:0]  left_q, left_d, pos, top_pos, last_pos;
  logic [TO_W-1:0]   to_q, to_d;
  logic [LONG_W-1:0] sr_q, sr_d;
  logic              long_q, long_d;
  logic              valid_q, valid_d, tout_q, tout_d;
  logic              bit_take, crc_en;

  assign top_pos  = long_q ? LONG_TOP : SHORT_LAST;
  assign last_pos = long_q ? LONG_LAST : SHORT_LAST;
  assign pos      = (st_q == RX_HUNT) ? last_pos : left_q;
  assign bit_take = rise_stb && (((st_q == RX_HUNT) && !cmd_in) || (st_q == RX_SHIFT));
  assign crc_en   = bit_take && (pos >= CRC_LOW) && (pos <= top_pos);

  always_comb begin
    st_d    = st_q;
    left_d  = left_q;
    to_d    = to_q;
    sr_d    = sr_q;
    long_d  = long_q;
    valid_d = 1'b0;
    tout_d  = 1'b0;
    if (arm) begin
      st_d   = RX_HUNT;
      to_d   = '0;
      long_d = long_sel;
    end else if (rise_stb) begin
      case (st_q)
        RX_HUNT: begin
          if (!cmd_in) begin
            sr_d   = {sr_q[LONG_W-2:0], 1'b0};
            left_d = last_pos - 1'b1;
            st_d   = RX_SHIFT;
          end else if (to_q == TO_LAST) begin
            tout_d = 1'b1;
            st_d   = RX_OFF;
          end else begin
            to_d = to_q + 1'b1;
          end
        end
        RX_SHIFT: begin
          sr_d = {sr_q[LONG_W-2:0], cmd_in};
          if (left_q == '0) begin
            valid_d = 1'b1;
            st_d    = RX_OFF;
          end else begin
            left_d = left_q - 1'b1;
          end
        end
        default: st_d = RX_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= RX_OFF;
      left_q  <= '0;
      to_q    <= '0;
      sr_q    <= '0;
      long_q  <= 1'b0;
      valid_q <= 1'b0;
      tout_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      left_q  <= left_d;
      to_q    <= to_d;
      sr_q    <= sr_d;
      long_q  <= long_d;
      valid_q <= valid_d;
      tout_q  <= tout_d;
    end
  end

  sdc_crc7_acc u_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (arm),
    .en    (crc_en),
    .d     (cmd_in),
    .crc   (crc_calc)
  );

  assign rsp_valid   = valid_q;
  assign rsp_timeout = tout_q;
  assign frame       = sr_q;

  a_r6_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);

  a_r8_no_valid_and_timeout: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid_q && tout_q));

endmodule

// File: rtl/sdc_cmd_path.sv
module sdc_cmd_path import sdc_cmd_pkg::*; #(
  parameter int CLK_DIV = 4,   // system clocks per SD clock, even and >= 4
  parameter int TO_CLKS = 64   // SD clocks allowed before the response start bit
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arg_we,
  input  logic [31:0]      arg_wdata,
  input  logic             cmd_we,
  input  logic [15:0]      cmd_wdata,
  input  logic             sts_clr_we,
  input  logic [STS_W-1:0] sts_clr_mask,
  output logic [STS_W-1:0] sts,
  output logic [31:0]      pstate,
  output logic [31:0]      resp0,
  output logic [31:0]      resp1,
  output logic [31:0]      resp2,
  output logic [31:0]      resp3,
  output logic             sd_clk,
  output logic             cmd_out,
  output logic             cmd_oe,
  input  logic             cmd_in,
  input  logic [3:0]       dat_in
);
  localparam int LONG_W = 136;

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_n_s    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n_s    <= rst_meta_q;
    end
  end

  logic fall_stb, rise_stb;
  sdc_clk_div #(.DIV(CLK_DIV)) u_div (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .sd_clk   (sd_clk),
    .fall_stb (fall_stb),
    .rise_stb (rise_stb)
  );

  seq_e              st_q, st_d;
  cmd_word_t         cur_q, cur_d, cw;
  logic [31:0]       arg_q, arg_d;
  logic [3:0]        dat_q;
  logic              busy_q, busy_d;
  logic [STS_W-1:0]  sts_q, sts_d, sts_set, clr_vec;
  logic [31:0]       r0_q, r1_q, r2_q, r3_q, r0_d, r1_d, r2_d, r3_d;
  logic              inh_cmd, inh_dat, accept;
  logic              tx_done, rx_arm, rsp_valid, rsp_timeout, rsp_upd;
  logic              crc_bad, idx_bad, rsp_long;
  logic [CMD_W-1:0]  tx_frame;
  logic [LONG_W-1:0] rx_frame;
  logic [6:0]        rx_crc;

  assign cw      = decode_cmd(cmd_wdata);
  assign inh_cmd = (st_q != ST_IDLE);
  assign inh_dat = busy_q;
  assign accept  = cmd_we && !inh_cmd &&
                   !((cw.kind == RSP_SHORT_BUSY) && !cw.dpres && inh_dat);
  assign tx_frame = {2'b01, cw.idx, arg_q,
                     crc7_of40({2'b01, cw.idx, arg_q}), 1'b1};
  assign rsp_long = (cur_q.kind == RSP_LONG);

  sdc_cmd_tx u_tx (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .load     (accept),
    .frame    (tx_frame),
    .fall_stb (fall_stb),
    .cmd_out  (cmd_out),
    .cmd_oe   (cmd_oe),
    .tx_done  (tx_done)
  );

  sdc_rsp_rx #(.LONG_W(LONG_W), .TO_CLKS(TO_CLKS)) u_rx (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .arm         (rx_arm),
    .long_sel    (rsp_long),
    .rise_stb    (rise_stb),
    .cmd_in      (cmd_in),
    .rsp_valid   (rsp_valid),
    .rsp_timeout (rsp_timeout),
    .frame       (rx_frame),
    .crc_calc    (rx_crc)
  );

  assign crc_bad = cur_q.crc_chk && (rx_crc != rx_frame[7:1]);
  assign idx_bad = cur_q.idx_chk && !rsp_long && (rx_frame[45:40] != cur_q.idx);

  // sequencer
  always_comb begin
    st_d    = st_q;
    cur_d   = cur_q;
    sts_set = '0;
    rx_arm  = 1'b0;
    rsp_upd = 1'b0;
    busy_d  = busy_q;
    if (busy_q && rise_stb && dat_q[0]) busy_d = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (accept) begin
          cur_d = cw;
          st_d  = ST_SEND;
        end
      end
      ST_SEND: begin
        if (tx_done) begin
          if (cur_q.kind == RSP_NONE) begin
            sts_set[STS_DONE] = 1'b1;
            st_d = ST_IDLE;
          end else begin
            rx_arm = 1'b1;
            st_d   = ST_RESP;
          end
        end
      end
      ST_RESP: begin
        if (rsp_timeout) begin
          sts_set[STS_TO]  = 1'b1;
          sts_set[STS_ERR] = 1'b1;
          st_d = ST_IDLE;
        end else if (rsp_valid) begin
          sts_set[STS_DONE] = 1'b1;
          sts_set[STS_CRC]  = crc_bad;
          sts_set[STS_IDX]  = idx_bad;
          sts_set[STS_ERR]  = crc_bad | idx_bad;
          rsp_upd = 1'b1;
          if (cur_q.kind == RSP_SHORT_BUSY) busy_d = 1'b1;
          st_d = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // software-visible registers
  always_comb begin
    arg_d   = arg_we ? arg_wdata : arg_q;
    clr_vec = sts_clr_we ? sts_clr_mask : '0;
    sts_d   = (sts_q & ~clr_vec) | sts_set;
    r0_d = r0_q;
    r1_d = r1_q;
    r2_d = r2_q;
    r3_d = r3_q;
    if (rsp_upd) begin
      if (rsp_long) {r3_d, r2_d, r1_d, r0_d} = {8'h00, rx_frame[127:8]};
      else          r0_d = rx_frame[39:8];
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      st_q   <= ST_IDLE;
      cur_q  <= '0;
      arg_q  <= '0;
      dat_q  <= '0;
      busy_q <= 1'b0;
      sts_q  <= '0;
      r0_q   <= '0;
      r1_q   <= '0;
      r2_q   <= '0;
      r3_q   <= '0;
    end else begin
      st_q   <= st_d;
      cur_q  <= cur_d;
      arg_q  <= arg_d;
      dat_q  <= dat_in;
      busy_q <= busy_d;
      sts_q  <= sts_d;
      r0_q   <= r0_d;
      r1_q   <= r1_d;
      r2_q   <= r2_d;
      r3_q   <= r3_d;
    end
  end

  assign sts    = sts_q;
  assign pstate = {8'h00, dat_q, 18'h0, inh_dat, inh_cmd};
  assign resp0  = r0_q;
  assign resp1  = r1_q;
  assign resp2  = r2_q;
  assign resp3  = r3_q;

  logic unused_ok;
  assign unused_ok = ^{cmd_wdata[15:14], cmd_wdata[7:6], cmd_wdata[2],
                       cur_q.dpres, rx_frame[135:128], rx_frame[0]};

  a_r2_cmd_steady_high: assert property (@(posedge clk) disable iff (!rst_n_s)
    (sd_clk && $past(sd_clk)) |-> $stable(cmd_out));

  a_r10_refused_write: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cmd_we && inh_cmd) |=> $stable(cur_q));

  a_r8_timeout_not_done: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(sts_q[STS_TO]) |-> !$rose(sts_q[STS_DONE]));

  a_r9_summary_follows: assert property (@(posedge clk) disable iff (!rst_n_s)
    ($rose(sts_q[STS_CRC]) || $rose(sts_q[STS_IDX])) |-> sts_q[STS_ERR]);

  a_r11_busy_release: assert property (@(posedge clk) disable iff (!rst_n_s)
    $fell(inh_dat) |-> $past(dat_q[0]));

endmodule

// File: tb/sdc_cmd_path_bench.sv
module sdc_cmd_path_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        arg_we = 1'b0, cmd_we = 1'b0, sts_clr_we = 1'b0;
  logic [31:0] arg_wdata = '0;
  logic [15:0] cmd_wdata = '0;
  logic [4:0]  sts_clr_mask = '0;
  logic [4:0]  sts;
  logic [31:0] pstate, resp0, resp1, resp2, resp3;
  logic        sd_clk, cmd_out, cmd_oe;
  logic        cmd_in = 1'b1;
  logic [3:0]  dat_in = 4'hF;

  always #5 clk = ~clk;

  sdc_cmd_path u_sdc_cmd_path (
    .clk(clk), .rst_n(rst_n), .arg_we(arg_we), .arg_wdata(arg_wdata),
    .cmd_we(cmd_we), .cmd_wdata(cmd_wdata), .sts_clr_we(sts_clr_we),
    .sts_clr_mask(sts_clr_mask), .sts(sts), .pstate(pstate),
    .resp0(resp0), .resp1(resp1), .resp2(resp2), .resp3(resp3),
    .sd_clk(sd_clk), .cmd_out(cmd_out), .cmd_oe(cmd_oe),
    .cmd_in(cmd_in), .dat_in(dat_in));

  int n_chk = 0, n_bad = 0, frames_seen = 0, frames_exp = 0;
  logic [47:0] exp_q[$];

  task automatic check(input string req, input logic [135:0] act, input logic [135:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] ref_crc(input logic [127:0] v, input int n);
    logic [6:0] c = '0;
    for (int i = n - 1; i >= 0; i--) begin
      logic fb = v[i] ^ c[6];
      c = {c[5:0], 1'b0};
      if (fb) c = c ^ 7'b0001001;
    end
    return c;
  endfunction

  function automatic logic [47:0] host_frame(input logic [5:0] idx, input logic [31:0] arg);
    return {2'b01, idx, arg, ref_crc({88'h0, 2'b01, idx, arg}, 40), 1'b1};
  endfunction

  function automatic logic [135:0] short_rsp(input logic [5:0] idx, input logic [31:0] st);
    return {88'h0, 2'b00, idx, st, ref_crc({88'h0, 2'b00, idx, st}, 40), 1'b1};
  endfunction

  // scoreboard monitor: assembles frames from the CMD line
  initial begin
    logic [47:0] sh;
    logic [47:0] e;
    int nb;
    sh = '0; nb = 0;
    forever begin
      @(posedge sd_clk); #1;
      if (cmd_oe) begin
        sh = {sh[46:0], cmd_out};
        nb++;
        if (nb == 48) begin
          frames_seen++;
          nb = 0;
          if (exp_q.size() == 0) check("R10 unexpected frame", {88'h0, sh}, '0);
          else begin
            e = exp_q.pop_front();
            check("R2 R3 frame", {88'h0, sh}, {88'h0, e});
          end
        end
      end else nb = 0;
    end
  end

  // driver: writes argument and command word, predicts the frame
  task automatic issue(input logic [5:0] idx, input logic [31:0] arg, input logic dp,
                       input logic ichk, input logic cchk, input logic [1:0] kind,
                       input bit accepted);
    @(negedge clk); arg_we = 1; arg_wdata = arg;
    @(negedge clk); arg_we = 0; cmd_we = 1;
    cmd_wdata = {2'b00, idx, 2'b00, dp, ichk, cchk, 1'b0, kind};
    if (accepted) begin exp_q.push_back(host_frame(idx, arg)); frames_exp++; end
    @(negedge clk); cmd_we = 0;
  endtask

  task automatic card_reply(input logic [135:0] bits, input int len, input int gap);
    @(negedge cmd_oe);
    repeat (gap) @(negedge sd_clk);
    #1;
    for (int i = len - 1; i >= 0; i--) begin
      cmd_in = bits[i];
      @(negedge sd_clk); #1;
    end
    cmd_in = 1'b1;
  endtask

  task automatic wait_idle();
    int g = 0;
    repeat (2) @(negedge clk);
    while (pstate[0] && g < 5000) begin @(negedge clk); g++; end
    @(negedge clk);
  endtask

  task automatic clear_sts(input logic [4:0] m);
    @(negedge clk); sts_clr_we = 1; sts_clr_mask = m;
    @(negedge clk); sts_clr_we = 0; sts_clr_mask = '0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000 - 10) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    logic [119:0] pl;
    logic [135:0] lr;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1 reset state, R13 DAT levels
    check("R1 sts", {131'h0, sts}, '0);
    check("R1 resp", {8'h0, resp3, resp2, resp1, resp0}, '0);
    check("R1 line", {134'h0, cmd_oe, cmd_out}, 136'h1);
    check("R13 pstate", {104'h0, pstate}, {104'h0, 32'h00F0_0000});

    // R5 no-response command, R3 known frame
    issue(6'd0, 32'h0, 0, 0, 0, 2'b00, 1);
    check("R10 inhibit set", {135'h0, pstate[0]}, 136'h1);
    wait_idle();
    check("R5 done", {131'h0, sts}, 136'h01);
    // R12 write-one-to-clear
    clear_sts(5'b00000);
    check("R12 zero write", {131'h0, sts}, 136'h01);
    clear_sts(5'b00001);
    check("R12 clear", {131'h0, sts}, '0);

    // R6 short response, R4 decode with checks on
    fork
      issue(6'd17, 32'h0000_0200, 0, 1, 1, 2'b10, 1);
      card_reply(short_rsp(6'd17, 32'h0000_0900), 48, 3);
    join
    wait_idle();
    check("R6 resp0", {104'h0, resp0}, {104'h0, 32'h0000_0900});
    check("R6 sts", {131'h0, sts}, 136'h01);
    clear_sts(5'h1F);

    // R9 CRC error with check on, then off
    fork
      issue(6'd13, 32'h1234_5678, 0, 1, 1, 2'b10, 1);
      card_reply(short_rsp(6'd13, 32'hCAFE_0001) ^ 136'h2, 48, 2);
    join
    wait_idle();
    check("R9 crc err", {131'h0, sts}, 136'h15);
    clear_sts(5'b00001);
    check("R12 partial clear", {131'h0, sts}, 136'h14);
    clear_sts(5'h1F);
    fork
      issue(6'd13, 32'h1234_5678, 0, 1, 0, 2'b10, 1);
      card_reply(short_rsp(6'd13, 32'hCAFE_0001) ^ 136'h2, 48, 2);
    join
    wait_idle();
    check("R9 crc off", {131'h0, sts}, 136'h01);
    clear_sts(5'h1F);

    // R9 index error on, then off
    fork
      issue(6'd55, 32'h0, 0, 1, 1, 2'b10, 1);
      card_reply(short_rsp(6'd54, 32'h0000_0120), 48, 2);
    join
    wait_idle();
    check("R9 idx err", {131'h0, sts}, 136'h19);
    clear_sts(5'h1F);
    fork
      issue(6'd55, 32'h0, 0, 0, 1, 2'b10, 1);
      card_reply(short_rsp(6'd54, 32'h0000_0120), 48, 2);
    join
    wait_idle();
    check("R9 idx off", {131'h0, sts}, 136'h01);
    clear_sts(5'h1F);

    // R7 long response
    pl = 120'h0123456789ABCDEF_FEDCBA98765432;
    lr = {2'b00, 6'h3F, pl, ref_crc({8'h0, pl}, 120), 1'b1};
    fork
      issue(6'd2, 32'h0, 0, 0, 1, 2'b01, 1);
      card_reply(lr, 136, 4);
    join
    wait_idle();
    check("R7 resp3", {104'h0, resp3}, {104'h0, 8'h00, pl[119:96]});
    check("R7 resp2", {104'h0, resp2}, {104'h0, pl[95:64]});
    check("R7 resp1", {104'h0, resp1}, {104'h0, pl[63:32]});
    check("R7 resp0", {104'h0, resp0}, {104'h0, pl[31:0]});
    check("R7 sts", {131'h0, sts}, 136'h01);
    clear_sts(5'h1F);

    // R8 late but in-window start bit, then no reply
    fork
      issue(6'd8, 32'h0000_01AA, 0, 1, 1, 2'b10, 1);
      card_reply(short_rsp(6'd8, 32'h0000_01AA), 48, 60);
    join
    wait_idle();
    check("R8 late ok", {131'h0, sts}, 136'h01);
    clear_sts(5'h1F);
    issue(6'd9, 32'h0, 0, 1, 1, 2'b10, 1);
    wait_idle();
    check("R8 timeout", {131'h0, sts}, 136'h12);
    clear_sts(5'h1F);

    // R10 command word during inhibit is ignored
    issue(6'd0, 32'h0, 0, 0, 0, 2'b00, 1);
    @(negedge clk); cmd_we = 1; cmd_wdata = 16'h0500;
    @(negedge clk); cmd_we = 0;
    wait_idle();
    repeat (400) @(negedge clk);
    check("R10 frames", frames_seen, frames_exp);
    clear_sts(5'h1F);

    // R11 busy wait on DAT0
    dat_in = 4'hE;
    fork
      issue(6'd7, 32'h0000_0001, 0, 1, 1, 2'b11, 1);
      card_reply(short_rsp(6'd7, 32'h0000_0700), 48, 2);
    join
    wait_idle();
    check("R11 sts", {131'h0, sts}, 136'h01);
    check("R11 inhibits", {134'h0, pstate[1:0]}, 136'h2);
    check("R13 dat", {132'h0, pstate[23:20]}, 136'hE);
    clear_sts(5'h1F);
    issue(6'd12, 32'h0, 0, 1, 1, 2'b11, 0);
    repeat (400) @(negedge clk);
    check("R11 refused", frames_seen, frames_exp);
    check("R11 no start", {135'h0, pstate[0]}, 136'h0);
    fork
      issue(6'd13, 32'h0001_0000, 0, 1, 1, 2'b10, 1);
      card_reply(short_rsp(6'd13, 32'h0000_0B00), 48, 2);
    join
    wait_idle();
    check("R11 other accepted", {104'h0, resp0}, {104'h0, 32'h0000_0B00});
    check("R11 still busy", {135'h0, pstate[1]}, 136'h1);
    dat_in = 4'hF;
    repeat (20) @(negedge clk);
    check("R11 released", {135'h0, pstate[1]}, 136'h0);
    check("R2 queue drained", exp_q.size(), 0);
    finish_run();
  end

endmodule